// File: doc/BRIEF.md
# Nibble-Serial Program Loader for a 24-bit Instruction Store

This block holds a 192-word by 24-bit instruction store and lets an external programmer fill and read it back four bits at a time. An internal pointer walks the store one nibble per increment pulse, six nibbles per word. The programmer clears the pointer, then pulses the increment line once per nibble. While the direction line is high, a strobe writes the presented nibble. While the direction line is low, the addressed nibble is shown on open-drain pull-down enables.

The four bits of each nibble do not map to contiguous word bits. They scatter across the instruction fields in a fixed order that the decoder next to the store depends on. A separate fetch port gives the processor core a whole word at a time.

Top module: `nib_prog_port`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle with `pgm_clr_n` low, no nibble is addressed. `pull_dn` is 0 and `done` is 0. A strobe in this state writes nothing, up to the first increment.
- R2: The pointer moves only when `step` was sampled high on one clock edge and low on the next. Holding `step` high or low leaves the pointer where it is.
- R3: The first falling `step` after a clear selects nibble 0 of word 0. Each later falling `step` moves to the next nibble.
- R4: For linear nibble count n, the addressed word is n/6 and the nibble index is n mod 6. `fetch_word` always shows the stored word at `fetch_addr`.
- R5: A write changes only the four word bits of the addressed nibble. The other 20 bits of that word, and all other words, keep their values.
- R6: The word layout from bit 0 upward is: Q[1:0], K[2:0], A[5:0], B[5:0], S[3:0], L[2:0]. The nibble contents, written MSB to LSB, are:
  - nibble 0 = {Q0, K2, K1, K0}
  - nibble 1 = {A2, B1, A1, Q1}
  - nibble 2 = {A4, B3, A3, B2}
  - nibble 3 = {A0, B5, A5, B4}
  - nibble 4 = {S2, S1, S0, B0}
  - nibble 5 = {L2, L1, L0, S3}
- R7: With `dir_in` low and a nibble addressed, `pull_dn[i]` is 1 exactly when the stored bit is 1, so that pin reads low (complemented readback). With `dir_in` high, `pull_dn` is 0.
- R8: Write data is taken true: a 1 on `dat_i[i]` stores a 1.
- R9: A falling `step` at nibble 1151 leaves the pointer at 1151 and sets `done`. `done` stays set until a clear or reset, and is 0 before that point.
- R10: A strobe with `dir_in` low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgm_clr_n | input | 1 | Active-low pointer clear |
| step | input | 1 | Increment; acts on its falling edge |
| dir_in | input | 1 | 1 = write mode, 0 = verify mode |
| strobe | input | 1 | Write qualifier |
| dat_i | input | 4 | Nibble from the programmer |
| pull_dn | output | 4 | Open-drain pull-down enables for readback |
| done | output | 1 | Pointer reached the end and was pushed further |
| fetch_addr | input | AW (8) | Core fetch word address |
| fetch_word | output | 24 | Stored word at `fetch_addr` |

## Verification
The bench builds the block with its default 192 words, so 1152 nibble steps reach the saturation point. A full write pass, a full verify pass and the overrun into `done` all fit in a short run. Filling every word first means the reference model knows every stored bit before any readback. Hand-derived word values for single-bit nibbles check the scattered mapping against figures worked out independently of the model.

// File: rtl/nib_prog_port.sv
module nib_prog_port #(
  parameter int WORDS = 192,
  localparam int AW = $clog2(WORDS),
  localparam int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_clr_n,
  input  logic          step,
  input  logic          dir_in,
  input  logic          strobe,
  input  logic [3:0]    dat_i,
  output logic [3:0]    pull_dn,
  output logic          done,
  input  logic [AW-1:0] fetch_addr,
  output logic [WW-1:0] fetch_word
);
  localparam logic [AW-1:0] LAST_W = AW'(WORDS - 1);
  localparam logic [2:0]    LAST_N = 3'd5;

  logic [WW-1:0] mem [WORDS];
  logic [AW-1:0] wptr;
  logic [2:0]    nidx;
  logic          valid, step_q, fall, wr_en, at_end;
  logic [WW-1:0] cur_word;
  logic [3:0]    rnib;

  function automatic logic [4:0] bpos(input logic [2:0] ix, input logic [1:0] b);
    case ({ix, b})
      {3'd0, 2'd3}: return 5'd0;
      {3'd0, 2'd2}: return 5'd4;
      {3'd0, 2'd1}: return 5'd3;
      {3'd0, 2'd0}: return 5'd2;
      {3'd1, 2'd3}: return 5'd7;
      {3'd1, 2'd2}: return 5'd12;
      {3'd1, 2'd1}: return 5'd6;
      {3'd1, 2'd0}: return 5'd1;
      {3'd2, 2'd3}: return 5'd9;
      {3'd2, 2'd2}: return 5'd14;
      {3'd2, 2'd1}: return 5'd8;
      {3'd2, 2'd0}: return 5'd13;
      {3'd3, 2'd3}: return 5'd5;
      {3'd3, 2'd2}: return 5'd16;
      {3'd3, 2'd1}: return 5'd10;
      {3'd3, 2'd0}: return 5'd15;
      {3'd4, 2'd3}: return 5'd19;
      {3'd4, 2'd2}: return 5'd18;
      {3'd4, 2'd1}: return 5'd17;
      {3'd4, 2'd0}: return 5'd11;
      {3'd5, 2'd3}: return 5'd23;
      {3'd5, 2'd2}: return 5'd22;
      {3'd5, 2'd1}: return 5'd21;
      {3'd5, 2'd0}: return 5'd20;
      default:      return 5'd0;
    endcase
  endfunction

  assign fall     = step_q & ~step;
  assign at_end   = (wptr == LAST_W) && (nidx == LAST_N);
  assign wr_en    = valid & dir_in & strobe;
  assign cur_word = mem[wptr];

  always_comb begin
    for (int b = 0; b < 4; b++) rnib[b] = cur_word[bpos(nidx, 2'(b))];
  end

  assign pull_dn    = (valid && !dir_in) ? rnib : 4'd0;
  assign fetch_word = mem[fetch_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      valid  <= 1'b0;
      wptr   <= '0;
      nidx   <= '0;
      done   <= 1'b0;
    end else begin
      step_q <= step;
      if (!pgm_clr_n) begin
        valid <= 1'b0;
        wptr  <= '0;
        nidx  <= '0;
        done  <= 1'b0;
      end else if (fall) begin
        if (!valid) valid <= 1'b1;
        else if (at_end) done <= 1'b1;
        else if (nidx == LAST_N) begin
          nidx <= '0;
          wptr <= wptr + 1'b1;
        end else nidx <= nidx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < 4; b++) mem[wptr][bpos(nidx, 2'(b))] <= dat_i[b];
  end
endmodule

// File: rtl/nib_prog_port_chk.sv
module nib_prog_port_chk #(
  parameter int WORDS = 192,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pgm_clr_n,
  input logic          step,
  input logic          dir_in,
  input logic          step_q,
  input logic          valid,
  input logic          done,
  input logic [AW-1:0] wptr,
  input logic [2:0]    nidx,
  input logic [3:0]    pull_dn
);
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_clr_n |=> (pull_dn == 4'd0 && !done));

  a_r2_no_fall_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_clr_n && !(step_q && !step)) |=> ($stable(wptr) && $stable(nidx) && $stable(valid)));

  a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (nidx < 3'd6) && (wptr <= AW'(WORDS - 1)));

  a_r7_write_dir_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in |-> pull_dn == 4'd0);

  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wptr == AW'(WORDS - 1) && nidx == 3'd5));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pgm_clr_n) |=> done);
endmodule

bind nib_prog_port nib_prog_port_chk #(.WORDS(WORDS), .AW(AW)) chk_i (.*);

// File: tb/nib_prog_port_tb_top.sv
module nib_prog_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 192;
  localparam int NIBS = WORDS * 6;
  localparam int AW = $clog2(WORDS);
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0, rst_n, pgm_clr_n, step, dir_in, strobe;
  logic [3:0] dat_i, pull_dn;
  logic done;
  logic [AW-1:0] fetch_addr;
  logic [23:0] fetch_word;

  nib_prog_port #(.WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pgm_clr_n(pgm_clr_n), .step(step),
    .dir_in(dir_in), .strobe(strobe), .dat_i(dat_i), .pull_dn(pull_dn),
    .done(done), .fetch_addr(fetch_addr), .fetch_word(fetch_word));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] get_nib(logic [23:0] w, int ix);
    logic [1:0] q = w[1:0];
    logic [2:0] k = w[4:2];
    logic [5:0] a = w[10:5];
    logic [5:0] b = w[16:11];
    logic [3:0] s = w[20:17];
    logic [2:0] l = w[23:21];
    case (ix)
      0: return {q[0], k[2], k[1], k[0]};
      1: return {a[2], b[1], a[1], q[1]};
      2: return {a[4], b[3], a[3], b[2]};
      3: return {a[0], b[5], a[5], b[4]};
      4: return {s[2], s[1], s[0], b[0]};
      default: return {l[2], l[1], l[0], s[3]};
    endcase
  endfunction

  function automatic logic [23:0] set_nib(logic [23:0] w, int ix, logic [3:0] n);
    logic [1:0] q = w[1:0];
    logic [2:0] k = w[4:2];
    logic [5:0] a = w[10:5];
    logic [5:0] b = w[16:11];
    logic [3:0] s = w[20:17];
    logic [2:0] l = w[23:21];
    case (ix)
      0: {q[0], k[2], k[1], k[0]} = n;
      1: {a[2], b[1], a[1], q[1]} = n;
      2: {a[4], b[3], a[3], b[2]} = n;
      3: {a[0], b[5], a[5], b[4]} = n;
      4: {s[2], s[1], s[0], b[0]} = n;
      default: {l[2], l[1], l[0], s[3]} = n;
    endcase
    return {l, s, b, a, k, q};
  endfunction

  bit m_valid, m_stepq, m_done, m_fall;
  int m_cnt;
  logic [23:0] m_mem [WORDS];
  logic [5:0]  m_mask [WORDS];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_stepq = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_fall = m_stepq && !step;
      m_stepq = step;
      if (m_valid && dir_in && strobe) begin
        m_mem[m_cnt / 6] = set_nib(m_mem[m_cnt / 6], m_cnt % 6, dat_i);
        m_mask[m_cnt / 6][m_cnt % 6] = 1'b1;
      end
      if (!pgm_clr_n) begin
        m_valid = 0; m_cnt = 0; m_done = 0;
      end else if (m_fall) begin
        if (!m_valid) begin m_valid = 1; m_cnt = 0; end
        else if (m_cnt == NIBS - 1) m_done = 1;
        else m_cnt++;
      end
    end
    #2;
    if (m_valid && !dir_in) begin
      if (m_mask[m_cnt / 6][m_cnt % 6])
        check("R7 verify nibble", 24'(pull_dn), 24'(get_nib(m_mem[m_cnt / 6], m_cnt % 6)));
    end else check("R7 no pull", 24'(pull_dn), 24'd0);
    check("R9 done", 24'(done), 24'(m_done));
    if (&m_mask[fetch_addr]) check("R4 fetch word", fetch_word, m_mem[fetch_addr]);
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_step();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] d);
    @(negedge clk) begin dat_i = d; dir_in = 1'b1; strobe = 1'b1; end
    @(negedge clk) strobe = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk) pgm_clr_n = 1'b0;
    @(negedge clk) pgm_clr_n = 1'b1;
  endtask

  task automatic set_dir(logic d);
    @(negedge clk) dir_in = d;
    @(negedge clk);
  endtask

  logic [23:0] w0, w1, w2;

  initial begin
    for (int i = 0; i < WORDS; i++) begin m_mem[i] = '0; m_mask[i] = '0; end
    rst_n = 1'b0; pgm_clr_n = 1'b1; step = 1'b0; dir_in = 1'b1;
    strobe = 1'b0; dat_i = '0; fetch_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pull_dn", 24'(pull_dn), 24'd0);
    check("R9 reset done", 24'(done), 24'd0);
    rst_n = 1'b1;

    // full write pass (R3, R4, R8)
    clr();
    for (int i = 0; i < NIBS; i++) begin
      pulse_step();
      fetch_addr = AW'(i / 6);
      wr(4'((i * 7 + 3) & 15));
    end
    check("R9 done low at last nibble", 24'(done), 24'd0);
    pulse_step();
    check("R9 done after overrun", 24'(done), 24'd1);
    pulse_step();
    check("R9 done held", 24'(done), 24'd1);
    set_dir(1'b0);
    check("R9 pointer saturated", 24'(pull_dn), 24'(((NIBS - 1) * 7 + 3) & 15));

    // full verify pass (R4, R7)
    clr();
    check("R9 done cleared", 24'(done), 24'd0);
    for (int i = 0; i < NIBS; i++) begin
      pulse_step();
      fetch_addr = AW'(i / 6);
    end

    // R1: strobe before first step ignored
    clr();
    @(negedge clk) begin dir_in = 1'b1; dat_i = 4'hF; strobe = 1'b1; end
    @(negedge clk) strobe = 1'b0;
    pulse_step();
    set_dir(1'b0);
    check("R1 pre-step strobe ignored", 24'(pull_dn), 24'h3);

    // R10: strobe in verify mode ignored
    @(negedge clk) begin dat_i = 4'hC; strobe = 1'b1; end
    @(negedge clk) strobe = 1'b0;
    @(negedge clk);
    check("R10 verify strobe ignored", 24'(pull_dn), 24'h3);

    // R3 R6 R8: hand-derived word 0
    clr();
    pulse_step(); wr(4'h8);
    pulse_step(); wr(4'h0);
    pulse_step(); wr(4'h0);
    pulse_step(); wr(4'h4);
    pulse_step(); wr(4'h0);
    pulse_step(); wr(4'h1);
    fetch_addr = '0;
    @(negedge clk);
    check("R6 mapping word0", fetch_word, 24'h110001);
    clr();
    pulse_step();
    set_dir(1'b0);
    check("R3 first step nibble0", 24'(pull_dn), 24'h8);

    // R5: rewrite word1 nibble1 only
    fetch_addr = AW'(1);
    @(negedge clk) w1 = fetch_word;
    fetch_addr = AW'(0);
    @(negedge clk) w0 = fetch_word;
    fetch_addr = AW'(2);
    @(negedge clk) w2 = fetch_word;
    for (int i = 0; i < 7; i++) pulse_step();
    wr(4'hF);
    fetch_addr = AW'(1);
    @(negedge clk);
    check("R5 word1 only nibble bits", fetch_word, w1 | 24'h0010C2);
    fetch_addr = AW'(0);
    @(negedge clk);
    check("R5 word0 untouched", fetch_word, w0);
    fetch_addr = AW'(2);
    @(negedge clk);
    check("R5 word2 untouched", fetch_word, w2);

    // R2: held step does not advance
    set_dir(1'b0);
    @(negedge clk) step = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 step held high", 24'(pull_dn), 24'hF);
    @(negedge clk) step = 1'b0;
    @(negedge clk);
    check("R2 step fell once", 24'(pull_dn), 24'(get_nib(m_mem[1], 2)));
    repeat (4) @(negedge clk);
    check("R2 step held low", 24'(pull_dn), 24'(get_nib(m_mem[1], 2)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule